// File: doc/BRIEF.md
# Multi-Core Pin Output Combiner

This block collects pin requests from several processor cores and turns them into one output-enable and one output-data bit per pin of a shared bidirectional pin bank. Each core keeps its own direction bit and output bit for every pin. A core's output bit only reaches the pin while that core's own direction bit is set. A pin is enabled when any core enables it. It is driven high when any enabling core holds its output bit high.

Cores change their bits through a small command port. Plain direction and output writes apply at once. The combined "drive" and "float" commands change both bits together. When both bits would change and the output changes level, the block splits the command into a break-before-make pair one clock apart:

- A float clears the direction bit first and moves the output bit on the next clock.
- A drive moves the output bit first and sets the direction bit on the next clock.

A per-pin mode bit chooses between two pad paths:

- Combinational: enable and data go straight to the pad.
- Registered: enable and data are both captured in flops on the same clock edge.

Pad input values pass straight through to the cores.

Top module: `core_pin_combiner`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every pad_oe and pad_do bit is 0. Reset clears every core's direction bit, output bit and pending second step.
- R2: Opcode 0 (direction write) and opcode 1 (output write) update the addressed bit of the issuing core on the clock edge that samples the command. The pad shows the effect in the cycle after that edge.
- R3: For every pin p, pad_oe[p] is the OR over all cores of dir[p], and pad_do[p] is the OR over all cores of (dir[p] AND out[p]).
- R4: Opcode 2 (drive, value v) on a pin whose direction bit is 0 and whose output bit differs from v sets the output bit at the first edge and the direction bit at the second edge.
- R5: Opcode 3 (float, value v) on a pin whose direction bit is 1 and whose output bit differs from v clears the direction bit at the first edge and sets the output bit to v at the second edge.
- R6: A drive or float that is not split as in R4 or R5 applies both of its bit updates at the first edge.
- R7: When pin_reg_mode[p] is 1, pad_oe[p] and pad_do[p] show the R3 values of the previous cycle, both delayed by the same single register stage. When it is 0, they show the current values.
- R8: pin_in equals pad_in in the same cycle.
- R9: pad_do is never 1 on a pin whose pad_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | NCORE | One command strobe per core |
| cmd_op | input | 2*NCORE | Per-core opcode: 0 direction write, 1 output write, 2 drive, 3 float |
| cmd_pin | input | NCORE*PW | Per-core pin index (PW = log2 NPIN) |
| cmd_val | input | NCORE | Per-core value bit |
| pin_reg_mode | input | NPIN | 1 selects the registered pad path for that pin |
| pad_in | input | NPIN | Sampled pad levels |
| pad_oe | output | NPIN | Pad output enable |
| pad_do | output | NPIN | Pad output data |
| pin_in | output | NPIN | Pad levels passed through to the cores |

## Verification
The checker assumes that a core never presents a new command in the clock after a drive or float command. This keeps the delayed second step of R4 and R5 from colliding with a new write from the same core. It also assumes that pin_reg_mode is held steady while outputs are expected to settle. The stimulus issues every command as a two-clock slot with the strobe low in the second clock, and keeps the mode word fixed for the whole run. Within those limits, the bench sweeps every opcode and value over all four starting direction/output states, on several pins in both pad modes. While doing so, another core holds a shared pin, so the OR merge is exercised as well.

// File: rtl/core_pin_combiner.sv
module core_pin_combiner #(
  parameter int NCORE = 4,
  parameter int NPIN  = 32,
  localparam int PW   = $clog2(NPIN)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCORE-1:0]      cmd_valid,
  input  logic [2*NCORE-1:0]    cmd_op,
  input  logic [NCORE*PW-1:0]   cmd_pin,
  input  logic [NCORE-1:0]      cmd_val,
  input  logic [NPIN-1:0]       pin_reg_mode,
  input  logic [NPIN-1:0]       pad_in,
  output logic [NPIN-1:0]       pad_oe,
  output logic [NPIN-1:0]       pad_do,
  output logic [NPIN-1:0]       pin_in
);
  localparam logic [1:0] OP_WRDIR = 2'd0;
  localparam logic [1:0] OP_WROUT = 2'd1;
  localparam logic [1:0] OP_DRV   = 2'd2;
  localparam logic [1:0] OP_FLT   = 2'd3;

  logic [NPIN-1:0] dir_all [NCORE];
  logic [NPIN-1:0] qual_all [NCORE];

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic [NPIN-1:0] dir_q, out_q;
    logic            pend_q, pend_dir_q, pend_val_q;
    logic [PW-1:0]   pend_pin_q;

    wire             go = cmd_valid[c];
    wire [1:0]       op = cmd_op[2*c +: 2];
    wire [PW-1:0]    pn = cmd_pin[PW*c +: PW];
    wire             v  = cmd_val[c];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dir_q      <= '0;
        out_q      <= '0;
        pend_q     <= 1'b0;
        pend_dir_q <= 1'b0;
        pend_val_q <= 1'b0;
        pend_pin_q <= '0;
      end else begin
        pend_q <= 1'b0;
        if (pend_q) begin
          if (pend_dir_q) dir_q[pend_pin_q] <= pend_val_q;
          else            out_q[pend_pin_q] <= pend_val_q;
        end
        if (go) begin
          case (op)
            OP_WRDIR: dir_q[pn] <= v;
            OP_WROUT: out_q[pn] <= v;
            OP_DRV: begin
              out_q[pn] <= v;
              if (!dir_q[pn] && out_q[pn] != v) begin
                pend_q     <= 1'b1;
                pend_dir_q <= 1'b1;
                pend_val_q <= 1'b1;
                pend_pin_q <= pn;
              end else begin
                dir_q[pn] <= 1'b1;
              end
            end
            default: begin
              dir_q[pn] <= 1'b0;
              if (dir_q[pn] && out_q[pn] != v) begin
                pend_q     <= 1'b1;
                pend_dir_q <= 1'b0;
                pend_val_q <= v;
                pend_pin_q <= pn;
              end else begin
                out_q[pn] <= v;
              end
            end
          endcase
        end
      end
    end

    assign dir_all[c]  = dir_q;
    assign qual_all[c] = dir_q & out_q;
  end

  logic [NPIN-1:0] oe_c, do_c, oe_r, do_r;

  always_comb begin
    oe_c = '0;
    do_c = '0;
    for (int i = 0; i < NCORE; i++) begin
      oe_c |= dir_all[i];
      do_c |= qual_all[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_r <= '0;
      do_r <= '0;
    end else begin
      oe_r <= oe_c;
      do_r <= do_c;
    end
  end

  assign pad_oe = (pin_reg_mode & oe_r) | (~pin_reg_mode & oe_c);
  assign pad_do = (pin_reg_mode & do_r) | (~pin_reg_mode & do_c);
  assign pin_in = pad_in;
endmodule

// File: rtl/core_pin_combiner_chk.sv
module core_pin_combiner_chk #(
  parameter int NCORE = 4,
  parameter int NPIN  = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCORE-1:0]     cmd_valid,
  input logic [2*NCORE-1:0]   cmd_op,
  input logic [NPIN-1:0]      pin_reg_mode,
  input logic [NPIN-1:0]      pad_oe,
  input logic [NPIN-1:0]      pad_do
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (pad_oe == '0 && pad_do == '0));

  // R9
  data_within_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_do & ~pad_oe) == '0);

  // R2
  idle_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_valid) == '0 && $past(cmd_valid, 2) == '0 && $past(cmd_valid, 3) == '0 &&
     $past(pin_reg_mode) == pin_reg_mode && $past(pin_reg_mode, 2) == pin_reg_mode)
    |-> ($stable(pad_oe) && $stable(pad_do)));

  for (genvar c = 0; c < NCORE; c++) begin : g_space
    // R4 R5
    two_clk_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid[c] && cmd_op[2*c+1]) |=> !cmd_valid[c]);
  end
endmodule

bind core_pin_combiner core_pin_combiner_chk #(.NCORE(NCORE), .NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .pin_reg_mode(pin_reg_mode), .pad_oe(pad_oe), .pad_do(pad_do)
);

// File: tb/core_pin_combiner_bench.sv
module core_pin_combiner_bench;
  localparam int NC = 4;
  localparam int NP = 32;
  localparam int PW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0]    cmd_valid = '0;
  logic [2*NC-1:0]  cmd_op = '0;
  logic [NC*PW-1:0] cmd_pin = '0;
  logic [NC-1:0]    cmd_val = '0;
  logic [NP-1:0]    mode = 32'hF0F0_0F0F;
  logic [NP-1:0]    pad_in = '0;
  logic [NP-1:0]    pad_oe, pad_do, pin_in;

  always #10 clk = ~clk;

  core_pin_combiner #(.NCORE(NC), .NPIN(NP)) u_core_pin_combiner (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pin(cmd_pin), .cmd_val(cmd_val), .pin_reg_mode(mode),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_do(pad_do), .pin_in(pin_in)
  );

  bit md [NC][NP];
  bit mo [NC][NP];
  logic [NP-1:0] prev_oe = '0, prev_do = '0;
  int vecs = 0, errs = 0;

  function automatic logic [NP-1:0] want_oe();
    logic [NP-1:0] r = '0;
    for (int c = 0; c < NC; c++)
      for (int p = 0; p < NP; p++) r[p] = r[p] | md[c][p];
    return r;
  endfunction

  function automatic logic [NP-1:0] want_do();
    logic [NP-1:0] r = '0;
    for (int c = 0; c < NC; c++)
      for (int p = 0; p < NP; p++) r[p] = r[p] | (md[c][p] & mo[c][p]);
    return r;
  endfunction

  task automatic check(string tag);
    logic [NP-1:0] eo, ed;
    eo = (mode & prev_oe) | (~mode & want_oe());
    ed = (mode & prev_do) | (~mode & want_do());
    vecs++;
    if (pad_oe !== eo || pad_do !== ed) begin
      errs++;
      $display("FAIL %s: oe=%h do=%h expected oe=%h do=%h", tag, pad_oe, pad_do, eo, ed);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(int c, int op, int p, bit v);
    bit split;
    string tag;
    split = (op == 2) ? (!md[c][p] && mo[c][p] != v) :
            (op == 3) ? ( md[c][p] && mo[c][p] != v) : 1'b0;
    if (op < 2)       tag = "R2 R3 R7";
    else if (!split)  tag = "R6 R3 R7";
    else if (op == 2) tag = "R4 R3 R7 R9";
    else              tag = "R5 R3 R7 R9";
    cmd_valid[c] = 1'b1;
    cmd_op[2*c +: 2] = op[1:0];
    cmd_pin[PW*c +: PW] = p[PW-1:0];
    cmd_val[c] = v;
    prev_oe = want_oe();
    prev_do = want_do();
    case (op)
      0: md[c][p] = v;
      1: mo[c][p] = v;
      2: begin mo[c][p] = v; if (!split) md[c][p] = 1'b1; end
      default: begin md[c][p] = 1'b0; if (!split) mo[c][p] = v; end
    endcase
    tick();
    cmd_valid[c] = 1'b0;
    check(tag);
    prev_oe = want_oe();
    prev_do = want_do();
    if (split) begin
      if (op == 2) md[c][p] = 1'b1;
      else         mo[c][p] = v;
    end
    tick();
    check(tag);
  endtask

  initial begin
    int pins [4] = '{0, 5, 22, 17};
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    tick();
    check("R1");

    pad_in = 32'hA5C3_0F96;
    #1;
    vecs++;
    if (pin_in !== pad_in) begin
      errs++;
      $display("FAIL R8: pin_in=%h expected %h", pin_in, pad_in);
    end
    pad_in = 32'h5A3C_F069;
    #1;
    vecs++;
    if (pin_in !== pad_in) begin
      errs++;
      $display("FAIL R8: pin_in=%h expected %h", pin_in, pad_in);
    end

    for (int c = 0; c < NC; c++) begin
      issue((c + 1) % NC, 2, 5, 1'b1);
      for (int pi = 0; pi < 4; pi++)
        for (int op = 0; op < 4; op++)
          for (int v = 0; v < 2; v++)
            for (int st = 0; st < 4; st++) begin
              issue(c, 1, pins[pi], st[0]);
              issue(c, 0, pins[pi], st[1]);
              issue(c, op, pins[pi], v[0]);
            end
      issue((c + 1) % NC, 3, 5, 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule